// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM with 8-bit word addresses and 16-bit data words. The host hands it one command at a time: read a word, write a word, or clear the device's write-protection register. The block builds the serial frames and clocks every bit out at a rate set by a divider parameter. It closes every frame by releasing chip select. After each internal program cycle in the device, it polls the device's ready status.

Commands enter over a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. A command presented while the block is busy is held off and has no effect until `cmd_ready` returns. Results leave on plain status pins, with no back-pressure: `done` pulses for one cycle when a sequence ends, `timeout_err` is valid only in that cycle, and `rd_data` holds the word from the latest read. The host must sample these pins when `done` is high.

A write always runs four frames in turn: an enable frame, a 27-bit program frame, a ready poll and a disable frame. Clearing protection runs an enable frame, then two frames with the protect-enable pin held high, then a ready poll.

Top module: `serial_eeprom_master`

## Requirements
- R1: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while idle, and `busy` is its inverse. `cmd_valid` while busy starts nothing and changes no state.
- R2: Each serial bit takes three phases of DIV clock cycles each. In the first, `mem_cs`=1, `mem_sck`=0 and `mem_mosi` carries the bit. In the second, `mem_sck`=1. In the third, `mem_sck`=0 again. `mem_mosi` and `mem_prot` do not change while `mem_sck` is high.
- R3: A read (`cmd_op`=0) runs as one chip-select window. The block shifts out a start bit 1, device opcode 10 and the 8-bit address, MSB first (11 bits). It then gives 16 more clocks and samples `mem_miso` at the end of each clock-high phase, assembling the word MSB first. `rd_data` changes only in the `done` cycle of a read.
- R4: A write (`cmd_op`=1) sends four frames in turn. First the enable frame: bits 1,0,0 then eight 1s. Next the program frame: start 1, opcode 01, address, then data, 27 bits MSB first. Then a ready poll. Last the disable frame: bit 1 then ten 0s.
- R5: The ready poll holds `mem_cs`=1 with `mem_sck`=0 and samples `mem_miso` every DIV cycles. It ends at the first sample that reads 1.
- R6: After POLL_LIMIT consecutive samples that read 0, the poll ends and the rest of the sequence still runs. `timeout_err` is then high in the `done` cycle. It is low on every other cycle.
- R7: Clearing protection (`cmd_op`=2) sends four parts in turn. First the enable frame. Then bits 1,0,0 plus eight 1s with `mem_prot`=1. Then eleven 1s with `mem_prot`=1. Then a ready poll. `mem_prot` is 0 during every other bit.
- R8: Every frame and every poll is followed by `mem_cs`=0 for at least DIV cycles. `mem_sck` is high only while `mem_cs` is high.
- R9: `done` is a one-cycle pulse at the end of a sequence, and `busy` is low in that same cycle. `cmd_op`=3 behaves exactly as a read.
- R10: Reset drives `mem_cs`, `mem_sck`, `mem_mosi`, `mem_prot`, `busy`, `done`, `timeout_err` and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 read, 1 write, 2 clear protection, 3 read |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Word to program |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout_err | output | 1 | Ready poll expired, valid with done |
| rd_data | output | 16 | Last word read |
| mem_cs | output | 1 | Chip select to the device |
| mem_sck | output | 1 | Serial clock to the device |
| mem_mosi | output | 1 | Serial data to the device |
| mem_miso | input | 1 | Serial data and ready status from the device |
| mem_prot | output | 1 | Protect-enable line, held alongside data |

## Verification
`busy` rises one cycle after a command is taken. `done` is due only after the whole frame list has run, and its timing depends on DIV and on how long the device model stays busy. Each bit costs three phases of DIV cycles plus two cycles of sequencing. Each step adds one more cycle, and a read with DIV=2 lasts roughly 230 cycles. For that reason the checks do not use fixed counts for `done`. They wait for the pulse and sample `rd_data`, `timeout_err` and `busy` on the falling edge of that cycle and of the next one. The device model counts pin timing cycle by cycle, and the checks after each command compare those counts with the expected values: clock-high length, chip-select gap, frame lengths and protect-enable clocks.

// File: rtl/eem_pkg.sv
package eem_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = 3;
  localparam int SHORT_W = HDR_W + ADDR_W;
  localparam int FRAME_W = SHORT_W + DATA_W;
  localparam int NBITS_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_UNPROT = 2'd2,
    OP_ALTRD  = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    PK_SEND, PK_RECV, PK_POLL, PK_DESEL
  } phy_kind_e;

  typedef enum logic [2:0] {
    ST_SEND, ST_RECV, ST_POLL, ST_DESEL, ST_END
  } step_kind_e;

  typedef struct packed {
    step_kind_e           kind;
    logic [FRAME_W-1:0]   word;
    logic [NBITS_W-1:0]   nbits;
    logic                 prot;
  } step_t;

  // short frame patterns, first bit sent is the MSB
  localparam logic [SHORT_W-1:0] PAT_ENABLE  = 11'b100_1111_1111;
  localparam logic [SHORT_W-1:0] PAT_DISABLE = 11'b100_0000_0000;
  localparam logic [SHORT_W-1:0] PAT_CLEAR   = 11'b111_1111_1111;
  localparam logic [HDR_W-1:0]   HDR_READ    = 3'b110;
  localparam logic [HDR_W-1:0]   HDR_PROG    = 3'b101;

  function automatic step_t mk_plain(step_kind_e k, int unsigned n);
    step_t s;
    s.kind  = k;
    s.word  = '0;
    s.nbits = NBITS_W'(n);
    s.prot  = 1'b0;
    return s;
  endfunction

  function automatic step_t mk_short(logic [SHORT_W-1:0] pat, logic prot);
    step_t s;
    s.kind  = ST_SEND;
    s.word  = {pat, {DATA_W{1'b0}}};
    s.nbits = NBITS_W'(SHORT_W);
    s.prot  = prot;
    return s;
  endfunction

  // Step list of each command; idx walks it from zero until ST_END.
  function automatic step_t plan_step(host_op_e op, logic [3:0] idx,
                                      logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step_t s;
    s = mk_plain(ST_END, 0);
    case (op)
      OP_WRITE: begin
        case (idx)
          4'd0: s = mk_short(PAT_ENABLE, 1'b0);
          4'd2: begin
            s.kind  = ST_SEND;
            s.word  = {HDR_PROG, a, d};
            s.nbits = NBITS_W'(FRAME_W);
            s.prot  = 1'b0;
          end
          4'd4: s = mk_plain(ST_POLL, 0);
          4'd6: s = mk_short(PAT_DISABLE, 1'b0);
          4'd1, 4'd3, 4'd5, 4'd7: s = mk_plain(ST_DESEL, 0);
          default: s = mk_plain(ST_END, 0);
        endcase
      end
      OP_UNPROT: begin
        case (idx)
          4'd0: s = mk_short(PAT_ENABLE, 1'b0);
          4'd2: s = mk_short(PAT_ENABLE, 1'b1);
          4'd4: s = mk_short(PAT_CLEAR, 1'b1);
          4'd6: s = mk_plain(ST_POLL, 0);
          4'd1, 4'd3, 4'd5, 4'd7: s = mk_plain(ST_DESEL, 0);
          default: s = mk_plain(ST_END, 0);
        endcase
      end
      default: begin
        case (idx)
          4'd0: begin
            s.kind  = ST_SEND;
            s.word  = {HDR_READ, a, {DATA_W{1'b0}}};
            s.nbits = NBITS_W'(SHORT_W);
            s.prot  = 1'b0;
          end
          4'd1: s = mk_plain(ST_RECV, DATA_W);
          4'd2: s = mk_plain(ST_DESEL, 0);
          default: s = mk_plain(ST_END, 0);
        endcase
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/eem_phase_timer.sv
module eem_phase_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eem_bitphy.sv
module eem_bitphy
  import eem_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  phy_kind_e req_kind,
  input  logic      req_bit,
  input  logic      req_prot,
  output logic      idle,
  output logic      ack,
  output logic      ack_bit,
  output logic      pin_cs,
  output logic      pin_sck,
  output logic      pin_mosi,
  output logic      pin_prot,
  input  logic      pin_miso
);
  logic      busy_q;
  logic [1:0] ph_q;
  phy_kind_e kind_q;
  logic      tick;
  logic      is_bit;
  logic [1:0] last_ph;
  logic      sample_now;

  eem_phase_timer #(.DIV(DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .tick (tick)
  );

  assign is_bit     = (kind_q == PK_SEND) || (kind_q == PK_RECV);
  assign last_ph    = is_bit ? 2'd2 : 2'd0;
  assign sample_now = is_bit ? (ph_q == 2'd1) : (kind_q == PK_POLL);
  assign idle       = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      ph_q     <= 2'd0;
      kind_q   <= PK_DESEL;
      ack      <= 1'b0;
      ack_bit  <= 1'b0;
      pin_cs   <= 1'b0;
      pin_sck  <= 1'b0;
      pin_mosi <= 1'b0;
      pin_prot <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (!busy_q) begin
        if (req) begin
          busy_q  <= 1'b1;
          ph_q    <= 2'd0;
          kind_q  <= req_kind;
          pin_sck <= 1'b0;
          case (req_kind)
            PK_SEND: begin
              pin_cs   <= 1'b1;
              pin_mosi <= req_bit;
              pin_prot <= req_prot;
            end
            PK_RECV, PK_POLL: begin
              pin_cs   <= 1'b1;
              pin_mosi <= 1'b0;
              pin_prot <= 1'b0;
            end
            default: begin
              pin_cs   <= 1'b0;
              pin_mosi <= 1'b0;
              pin_prot <= 1'b0;
            end
          endcase
        end
      end else if (tick) begin
        if (sample_now) ack_bit <= pin_miso;
        if (ph_q == last_ph) begin
          busy_q <= 1'b0;
          ack    <= 1'b1;
        end else begin
          ph_q    <= ph_q + 2'd1;
          pin_sck <= (ph_q == 2'd0);
        end
      end
    end
  end
endmodule

// File: rtl/eem_seq.sv
module eem_seq
  import eem_pkg::*;
#(
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              done,
  output logic              timeout_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              phy_req,
  output phy_kind_e         phy_kind,
  output logic              phy_bit,
  output logic              phy_prot,
  input  logic              phy_ack,
  input  logic              phy_ack_bit
);
  localparam int PC_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_ISSUE, SQ_WAIT} seq_state_e;

  seq_state_e         state_q;
  host_op_e           op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [3:0]         idx_q;
  step_kind_e         kind_q;
  logic [FRAME_W-1:0] sh_q;
  logic [NBITS_W-1:0] left_q;
  logic               prot_q;
  logic [DATA_W-1:0]  rx_q;
  logic [PC_W-1:0]    pcnt_q;
  logic               err_q;
  step_t              cur;
  logic               last_bit;
  logic               is_read;

  assign cur       = plan_step(op_q, idx_q, addr_q, data_q);
  assign cmd_ready = (state_q == SQ_IDLE);
  assign phy_req   = (state_q == SQ_ISSUE);
  assign phy_bit   = sh_q[FRAME_W-1];
  assign phy_prot  = prot_q;
  assign last_bit  = (left_q == NBITS_W'(1));
  assign is_read   = (op_q != OP_WRITE) && (op_q != OP_UNPROT);

  always_comb begin
    case (kind_q)
      ST_SEND: phy_kind = PK_SEND;
      ST_RECV: phy_kind = PK_RECV;
      ST_POLL: phy_kind = PK_POLL;
      default: phy_kind = PK_DESEL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      op_q        <= OP_READ;
      addr_q      <= '0;
      data_q      <= '0;
      idx_q       <= '0;
      kind_q      <= ST_END;
      sh_q        <= '0;
      left_q      <= '0;
      prot_q      <= 1'b0;
      rx_q        <= '0;
      pcnt_q      <= '0;
      err_q       <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      rd_data     <= '0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (cmd_valid) begin
            op_q    <= host_op_e'(cmd_op);
            addr_q  <= cmd_addr;
            data_q  <= cmd_wdata;
            idx_q   <= '0;
            err_q   <= 1'b0;
            state_q <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          if (cur.kind == ST_END) begin
            state_q     <= SQ_IDLE;
            done        <= 1'b1;
            timeout_err <= err_q;
            if (is_read) rd_data <= rx_q;
          end else begin
            kind_q  <= cur.kind;
            sh_q    <= cur.word;
            left_q  <= cur.nbits;
            prot_q  <= cur.prot;
            pcnt_q  <= '0;
            state_q <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: state_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (phy_ack) begin
            case (kind_q)
              ST_SEND, ST_RECV: begin
                sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
                left_q <= left_q - NBITS_W'(1);
                if (kind_q == ST_RECV) rx_q <= {rx_q[DATA_W-2:0], phy_ack_bit};
                if (last_bit) begin
                  idx_q   <= idx_q + 4'd1;
                  state_q <= SQ_LOAD;
                end else begin
                  state_q <= SQ_ISSUE;
                end
              end
              ST_POLL: begin
                if (phy_ack_bit) begin
                  idx_q   <= idx_q + 4'd1;
                  state_q <= SQ_LOAD;
                end else if (pcnt_q == PC_W'(POLL_LIMIT - 1)) begin
                  err_q   <= 1'b1;
                  idx_q   <= idx_q + 4'd1;
                  state_q <= SQ_LOAD;
                end else begin
                  pcnt_q  <= pcnt_q + 1'b1;
                  state_q <= SQ_ISSUE;
                end
              end
              default: begin
                idx_q   <= idx_q + 4'd1;
                state_q <= SQ_LOAD;
              end
            endcase
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_eeprom_master.sv
module serial_eeprom_master
  import eem_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int POLL_LIMIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic        timeout_err,
  output logic [15:0] rd_data,
  output logic        mem_cs,
  output logic        mem_sck,
  output logic        mem_mosi,
  input  logic        mem_miso,
  output logic        mem_prot
);
  logic      phy_req;
  phy_kind_e phy_kind;
  logic      phy_bit;
  logic      phy_prot;
  logic      phy_ack;
  logic      phy_ack_bit;
  logic      phy_idle;

  eem_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .done       (done),
    .timeout_err(timeout_err),
    .rd_data    (rd_data),
    .phy_req    (phy_req),
    .phy_kind   (phy_kind),
    .phy_bit    (phy_bit),
    .phy_prot   (phy_prot),
    .phy_ack    (phy_ack),
    .phy_ack_bit(phy_ack_bit)
  );

  eem_bitphy #(.DIV(DIV)) u_phy (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (phy_req),
    .req_kind(phy_kind),
    .req_bit (phy_bit),
    .req_prot(phy_prot),
    .idle    (phy_idle),
    .ack     (phy_ack),
    .ack_bit (phy_ack_bit),
    .pin_cs  (mem_cs),
    .pin_sck (mem_sck),
    .pin_mosi(mem_mosi),
    .pin_prot(mem_prot),
    .pin_miso(mem_miso)
  );

  assign busy = !cmd_ready;
endmodule

// File: rtl/serial_eeprom_master_chk.sv
module serial_eeprom_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        busy,
  input logic        done,
  input logic        timeout_err,
  input logic [15:0] rd_data,
  input logic        mem_cs,
  input logic        mem_sck,
  input logic        mem_mosi,
  input logic        mem_prot
);
  // R8
  sck_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sck |-> mem_cs);

  // R8
  sck_rise_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sck) |-> $past(mem_cs));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sck |-> ($stable(mem_mosi) && $stable(mem_prot)));

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));
endmodule

bind serial_eeprom_master serial_eeprom_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .busy       (busy),
  .done       (done),
  .timeout_err(timeout_err),
  .rd_data    (rd_data),
  .mem_cs     (mem_cs),
  .mem_sck    (mem_sck),
  .mem_mosi   (mem_mosi),
  .mem_prot   (mem_prot)
);

// File: tb/tb_serial_eeprom_master.sv
`timescale 1ns/100ps
module tb_serial_eeprom_master;
  localparam int DIV  = 2;
  localparam int PLIM = 16;
  localparam int BUSY = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_addr = 8'd0;
  logic [15:0] cmd_wdata = 16'd0;
  logic cmd_ready, busy, done, timeout_err;
  logic [15:0] rd_data;
  logic mem_cs, mem_sck, mem_mosi, mem_prot;
  logic miso_q = 1'b1;

  always #2.5 clk = ~clk;

  serial_eeprom_master #(.DIV(DIV), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .done(done), .timeout_err(timeout_err), .rd_data(rd_data), .mem_cs(mem_cs),
    .mem_sck(mem_sck), .mem_mosi(mem_mosi), .mem_miso(miso_q), .mem_prot(mem_prot)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mem [256];
  logic prev_cs = 1'b0, prev_sk = 1'b0;
  int edges = 0, busy_cnt = 0, low_run = 0, hi_run = 0;
  logic [26:0] bits = '0;
  logic frame_pe = 1'b0, reading = 1'b0;
  logic [7:0] rd_addr = 8'd0;
  logic we = 1'b0, pr_en = 1'b0, protd = 1'b1, stuck = 1'b0;
  int flen [8];
  int nframes = 0, pe_total = 0, min_low = 999, sk_min = 999, sk_max = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = {8'(i), ~8'(i)};

  always @(posedge clk) begin
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (mem_cs && !prev_cs) begin
      edges = 0; bits = '0; frame_pe = 1'b0;
      if (low_run < min_low) min_low = low_run;
    end
    if (!mem_cs) low_run++; else low_run = 0;
    if (mem_sck) hi_run++;
    else if (prev_sk) begin
      if (hi_run < sk_min) sk_min = hi_run;
      if (hi_run > sk_max) sk_max = hi_run;
      hi_run = 0;
    end
    if (mem_cs && mem_sck && !prev_sk) begin
      edges++;
      bits = {bits[25:0], mem_mosi};
      if (mem_prot) begin frame_pe = 1'b1; pe_total++; end
      if (edges == 11 && bits[10:8] == 3'b110) begin
        reading = 1'b1; rd_addr = bits[7:0];
      end else if (reading && edges >= 12 && edges <= 27)
        miso_q <= mem[rd_addr][27-edges];
    end
    if (!mem_cs && prev_cs) begin
      if (edges == 11) begin
        if (bits[10:0] == 11'b100_1111_1111) begin
          if (frame_pe) pr_en = 1'b1; else we = 1'b1;
        end else if (bits[10:0] == 11'b100_0000_0000) we = 1'b0;
        else if (bits[10:0] == 11'h7FF && frame_pe && pr_en) begin
          protd = 1'b0; pr_en = 1'b0; busy_cnt = BUSY;
        end
      end else if (edges == 27 && bits[26:24] == 3'b101 && we && !protd) begin
        mem[bits[23:16]] = bits[15:0]; busy_cnt = BUSY;
      end
      if (nframes < 8) flen[nframes] = edges;
      nframes++;
      reading = 1'b0;
    end
    if (!reading) miso_q <= !stuck && (busy_cnt == 0);
    prev_cs = mem_cs;
    prev_sk = mem_sck;
  end

  // ---------------- stimulus helpers ----------------
  logic got_done, got_err;
  logic [15:0] got_rd;

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    int n;
    @(negedge clk);
    nframes = 0; pe_total = 0; min_low = 999; sk_min = 999; sk_max = 0;
    check(cmd_ready == 1'b1, "R1", "ready before command", 32'(cmd_ready), 1);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    got_done = done; got_err = timeout_err; got_rd = rd_data;
  endtask

  task automatic check_frames(input logic [1:0] op, input string tag);
    int e0, e1, e2, e3, en, epe;
    case (op)
      2'd1: begin en = 4; e0 = 11; e1 = 27; e2 = 0;  e3 = 11; epe = 0;  end
      2'd2: begin en = 4; e0 = 11; e1 = 11; e2 = 11; e3 = 0;  epe = 22; end
      default: begin en = 1; e0 = 27; e1 = 0; e2 = 0; e3 = 0; epe = 0; end
    endcase
    check(nframes == en, tag, "frame count", 32'(nframes), 32'(en));
    check(flen[0] == e0, tag, "frame 0 clocks", 32'(flen[0]), 32'(e0));
    if (en == 4) begin
      check(flen[1] == e1, tag, "frame 1 clocks", 32'(flen[1]), 32'(e1));
      check(flen[2] == e2, tag, "frame 2 clocks", 32'(flen[2]), 32'(e2));
      check(flen[3] == e3, tag, "frame 3 clocks", 32'(flen[3]), 32'(e3));
    end
    check(pe_total == epe, "R7", "clocks with protect high", 32'(pe_total), 32'(epe));
    check(sk_min == DIV && sk_max == DIV, "R2", "clock high length", 32'(sk_max), 32'(DIV));
    check(min_low >= DIV, "R8", "select gap", 32'(min_low), 32'(DIV));
  endtask

  // {op, addr, wdata, expected}
  localparam logic [41:0] VEC [0:10] = '{
    {2'd1, 8'h21, 16'hBEEF, 16'h21DE},
    {2'd2, 8'h00, 16'h0000, 16'h0000},
    {2'd1, 8'h21, 16'hBEEF, 16'hBEEF},
    {2'd1, 8'hA5, 16'h1234, 16'h1234},
    {2'd1, 8'h00, 16'hFFFF, 16'hFFFF},
    {2'd1, 8'hFF, 16'h0001, 16'h0001},
    {2'd0, 8'hA5, 16'h0000, 16'h1234},
    {2'd0, 8'h00, 16'h0000, 16'hFFFF},
    {2'd0, 8'h21, 16'h0000, 16'hBEEF},
    {2'd0, 8'h3C, 16'h0000, 16'h3CC3},
    {2'd3, 8'hFF, 16'h0000, 16'h0001}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] last_rd;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({mem_cs, mem_sck, mem_mosi, mem_prot} == 4'b0, "R10", "pins in reset",
          32'({mem_cs, mem_sck, mem_mosi, mem_prot}), 0);
    check(busy == 1'b0 && done == 1'b0 && timeout_err == 1'b0, "R10", "status in reset",
          32'({busy, done, timeout_err}), 0);
    check(rd_data == 16'h0, "R10", "rd_data in reset", 32'(rd_data), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cmd_ready == 1'b1 && busy == 1'b0, "R1", "idle after reset", 32'({cmd_ready, busy}), 2);
    last_rd = 16'h0;

    for (int i = 0; i < 11; i++) begin
      logic [1:0] op;
      logic [7:0] a;
      logic [15:0] wd, ex;
      {op, a, wd, ex} = VEC[i];
      run_cmd(op, a, wd);
      check(got_done == 1'b1, "R9", "done seen", 32'(got_done), 1);
      check(busy == 1'b0, "R9", "busy low with done", 32'(busy), 0);
      check(got_err == 1'b0, "R6", "no timeout", 32'(got_err), 0);
      @(negedge clk);
      check(done == 1'b0, "R9", "done lasts one cycle", 32'(done), 0);
      if (op == 2'd1) begin
        check(mem[a] == ex, "R4", "programmed word", 32'(mem[a]), 32'(ex));
        check(we == 1'b0, "R4", "disable frame sent", 32'(we), 0);
        check(got_rd == last_rd, "R3", "rd_data held over write", 32'(got_rd), 32'(last_rd));
        check_frames(op, "R4");
      end else if (op == 2'd2) begin
        check(protd == 1'b0, "R7", "protection cleared", 32'(protd), 0);
        check_frames(op, "R7");
      end else begin
        check(got_rd == ex, (op == 2'd3) ? "R9" : "R3", "read word", 32'(got_rd), 32'(ex));
        last_rd = got_rd;
        check_frames(op, "R3");
      end
    end

    // R1: command offered while busy is ignored
    @(negedge clk);
    nframes = 0;
    cmd_op = 2'd0; cmd_addr = 8'h21; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 2'd1; cmd_addr = 8'h21; cmd_wdata = 16'h0000;
    for (int k = 0; k < 20; k++) begin
      if (k == 5) check(cmd_ready == 1'b0 && busy == 1'b1, "R1", "ready low while busy",
                        32'({cmd_ready, busy}), 1);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    begin
      int n = 0;
      while (!done && n < 20000) begin @(negedge clk); n++; end
    end
    check(rd_data == 16'hBEEF, "R3", "read under busy offer", 32'(rd_data), 32'hBEEF);
    check(mem[8'h21] == 16'hBEEF, "R1", "offered write had no effect", 32'(mem[8'h21]), 32'hBEEF);
    check(nframes == 1, "R1", "only one sequence ran", 32'(nframes), 1);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R1", "idle after ignored offer", 32'(busy), 0);

    // R6 / R5: device never reports ready
    stuck = 1'b1;
    run_cmd(2'd1, 8'h40, 16'h5555);
    check(got_done == 1'b1, "R6", "done after timeout", 32'(got_done), 1);
    check(got_err == 1'b1, "R6", "timeout flag", 32'(got_err), 1);
    check_frames(2'd1, "R6");
    @(negedge clk);
    check(timeout_err == 1'b0, "R6", "flag only with done", 32'(timeout_err), 0);
    stuck = 1'b0;
    run_cmd(2'd0, 8'h40, 16'h0000);
    check(got_err == 1'b0, "R5", "poll ends on ready", 32'(got_err), 0);
    check(got_rd == 16'h5555, "R3", "read after timeout write", 32'(got_rd), 32'h5555);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule